// File: doc/BRIEF.md
# Double-Buffered Time Slot Interchanger

This block reorders the byte-wide samples of a time-division frame. A frame carries 24 slots of 8-bit PCM, and slot numbers run 0 to 23. Input bytes arrive in slot order, and a strobe marks slot 0. Each byte goes into a buffer RAM at an indirect address. That address is the entry of a connection table indexed by the current input slot. The output side walks the buffer in plain slot order, so a byte that entered in slot s leaves in slot map[s].

The buffer holds two frames of 48 bytes. Words 0 to 23 form half 0 and words 24 to 47 form half 1. While input fills one half, output drains the other. The input half changes when slot 23 is written. At its own frame strobe, the output side claims the most recently completed half, so its frame phase may lag the input phase freely.

A processor writes table entries into a shadow copy. The shadow becomes live on the next input frame strobe, so every frame is switched with a single mapping. An error pulse reports the case where an input frame completes while the output side still owns the half the input needs next.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `out_valid` and `frame_err` are 0, every table entry equals its own index (slot s maps to s), and the buffer holds zeros. Input bytes are dropped until the first `in_sof`.
- R2: An input byte in slot s is written to buffer word `H*24 + map[s]`, where H is the input half. A byte with `in_sof` is slot 0, and each later `in_valid` byte is the next slot.
- R3: A read strobe `out_rd` for output slot j of half H yields `out_valid`=1 with the byte at word `H*24 + j` on the next cycle. `out_sof` marks j=0, and each later strobe reads the next slot.
- R4: Writing slot 23 swaps the input half. An output strobe with `out_sof` takes the half most recently completed before that cycle, which is the half the input is not filling.
- R5: A processor write (`cpu_we`, `cpu_addr`, `cpu_data`) changes only the shadow table. The live table copies the shadow on an input byte carrying `in_sof`, and that byte already uses the new entries. A write in the same cycle as `in_sof` first applies to the following frame.
- R6: A processor write with `cpu_addr` ≥ 24 or `cpu_data` ≥ 24 is ignored.
- R7: Input bytes beyond slot 23 without a new `in_sof` are dropped. Read strobes beyond slot 23 give no `out_valid`.
- R8: The output frame may start any number of cycles after the input frame completes. No error is raised if the output finishes its half no later than the cycle in which the next input frame completes.
- R9: `frame_err` is a one-cycle pulse, raised in the cycle after an input frame completes while the output side still owns the half that input writes next. This includes an output frame started in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is slot 0 |
| in_data | input | 8 | Input sample |
| out_rd | input | 1 | Read strobe for the next output slot |
| out_sof | input | 1 | Read strobe is output slot 0 |
| out_valid | output | 1 | `out_data` holds a read result |
| out_data | output | 8 | Output sample |
| cpu_we | input | 1 | Table write enable |
| cpu_addr | input | 5 | Table entry (input slot) |
| cpu_data | input | 5 | Buffer slot that input slot maps to |
| frame_err | output | 1 | Half-reuse error pulse |

## Verification
The main function is run with the reset identity map, which tells slot-order handling apart from table lookup. It is also run with a table rewritten at random moments, including writes that land on the frame strobe, which shows whether shadow loading happens at the right boundary. Input paced every second and third cycle, with output lags from zero up to the largest legal value, separates correct half selection from a design that reads the half being filled. Back-to-back input frames with zero lag probe the release-in-the-same-cycle edge, and a one-cycle lag must raise the error pulse. Extra bytes and extra strobes past slot 23, plus out-of-range table writes, must leave the outputs unchanged.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int unsigned TSI_SLOTS = 24;
   localparam int unsigned TSI_DW    = 8;

   // word offset of a buffer half
   function automatic int unsigned half_base(logic half, int unsigned slots);
      return half ? slots : 0;
   endfunction
endpackage

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
   parameter int unsigned SLOTS = 24,
   localparam int unsigned SW = $clog2(SLOTS),
   localparam int unsigned CW = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [SW-1:0] cpu_addr,
   input  logic [SW-1:0] cpu_data,
   input  logic          load,
   input  logic [SW-1:0] rd_slot,
   input  logic          rd_use_shadow,
   output logic [SW-1:0] map_out
);
   logic [SW-1:0] shadow_q [SLOTS];
   logic [SW-1:0] active_q [SLOTS];
   logic          cpu_ok;

   assign cpu_ok = cpu_we && (CW'(cpu_addr) < CW'(SLOTS)) && (CW'(cpu_data) < CW'(SLOTS));

   for (genvar g = 0; g < SLOTS; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)                                shadow_q[g] <= SW'(g);
         else if (cpu_ok && cpu_addr == SW'(g))     shadow_q[g] <= cpu_data;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)    active_q[g] <= SW'(g);
         else if (load) active_q[g] <= shadow_q[g];
      end
   end

   assign map_out = rd_use_shadow ? shadow_q[rd_slot] : active_q[rd_slot];

   p_map_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(rd_slot) < CW'(SLOTS)) |-> (CW'(map_out) < CW'(SLOTS)))
      else $error("table entry out of range");
endmodule

// File: rtl/tsi_in_ctrl.sv
module tsi_in_ctrl #(
   parameter int unsigned SLOTS = 24,
   localparam int unsigned SW = $clog2(SLOTS),
   localparam int unsigned CW = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sof,
   output logic          wr_en,
   output logic [SW-1:0] wr_slot,
   output logic          use_shadow,
   output logic          load,
   output logic          wr_half,
   output logic          done
);
   logic [CW-1:0] slot_q;
   logic [CW-1:0] cur;

   assign cur        = in_sof ? '0 : slot_q;
   assign wr_en      = in_valid && (cur < CW'(SLOTS));
   assign wr_slot    = cur[SW-1:0];
   assign use_shadow = in_sof;
   assign load       = in_valid && in_sof;
   assign done       = wr_en && (cur == CW'(SLOTS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q  <= CW'(SLOTS);
         wr_half <= 1'b0;
      end else begin
         if (wr_en) slot_q  <= cur + CW'(1);
         if (done)  wr_half <= ~wr_half;
      end
   end

   p_done_swaps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (wr_half != $past(wr_half)))
      else $error("input half did not swap");
endmodule

// File: rtl/tsi_out_ctrl.sv
module tsi_out_ctrl #(
   parameter int unsigned SLOTS = 24,
   localparam int unsigned AW = $clog2(2 * SLOTS),
   localparam int unsigned CW = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          out_rd,
   input  logic          out_sof,
   input  logic          wr_half,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   output logic          busy_nx,
   output logic          half_nx
);
   logic [CW-1:0] slot_q;
   logic [CW-1:0] cur;
   logic          half_q, busy_q, half, last;

   assign cur   = out_sof ? '0 : slot_q;
   assign half  = out_sof ? ~wr_half : half_q;
   assign rd_en = out_rd && (cur < CW'(SLOTS));
   assign last  = rd_en && (cur == CW'(SLOTS - 1));
   assign rd_addr = AW'(tsi_pkg::half_base(half, SLOTS)) + AW'(cur);

   always_comb begin
      busy_nx = busy_q;
      half_nx = half_q;
      if (rd_en && out_sof) begin
         busy_nx = 1'b1;
         half_nx = half;
      end
      if (last) busy_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= CW'(SLOTS);
         half_q <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         if (rd_en) slot_q <= cur + CW'(1);
         half_q <= half_nx;
         busy_q <= busy_nx;
      end
   end

   p_read_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr < AW'(2 * SLOTS)))
      else $error("read address out of range");
endmodule

// File: rtl/tsi_buffer.sv
module tsi_buffer #(
   parameter int unsigned SLOTS = 24,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW = $clog2(2 * SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic          rvalid,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [2*SLOTS];

   for (genvar g = 0; g < 2 * SLOTS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)                         mem[g] <= '0;
         else if (we && waddr == AW'(g))     mem[g] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= re;
         if (re) rdata <= mem[raddr];
      end
   end

   p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (waddr < AW'(2 * SLOTS)))
      else $error("write address out of range");

   p_valid_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      re |=> rvalid)
      else $error("read gave no valid");
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
   parameter int unsigned SLOTS = tsi_pkg::TSI_SLOTS,
   parameter int unsigned DW    = tsi_pkg::TSI_DW,
   localparam int unsigned SW = $clog2(SLOTS),
   localparam int unsigned AW = $clog2(2 * SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sof,
   input  logic [DW-1:0] in_data,
   input  logic          out_rd,
   input  logic          out_sof,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   input  logic          cpu_we,
   input  logic [SW-1:0] cpu_addr,
   input  logic [SW-1:0] cpu_data,
   output logic          frame_err
);
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be at least 1");
   end

   logic          wr_en, use_shadow, load, wr_half, done;
   logic [SW-1:0] wr_slot, map;
   logic          rd_en, busy_nx, half_nx;
   logic [AW-1:0] rd_addr, wr_addr;

   tsi_in_ctrl #(.SLOTS(SLOTS)) u_in (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .wr_en(wr_en), .wr_slot(wr_slot), .use_shadow(use_shadow),
      .load(load), .wr_half(wr_half), .done(done));

   tsi_conn_mem #(.SLOTS(SLOTS)) u_map (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_data(cpu_data), .load(load), .rd_slot(wr_slot),
      .rd_use_shadow(use_shadow), .map_out(map));

   assign wr_addr = AW'(tsi_pkg::half_base(wr_half, SLOTS)) + AW'(map);

   tsi_out_ctrl #(.SLOTS(SLOTS)) u_out (
      .clk(clk), .rst_n(rst_n), .out_rd(out_rd), .out_sof(out_sof),
      .wr_half(wr_half), .rd_en(rd_en), .rd_addr(rd_addr),
      .busy_nx(busy_nx), .half_nx(half_nx));

   tsi_buffer #(.SLOTS(SLOTS), .DW(DW)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
      .re(rd_en), .raddr(rd_addr), .rvalid(out_valid), .rdata(out_data));

   // the half input moves to next is ~wr_half; error if output still owns it
   always_ff @(posedge clk) begin
      if (!rst_n) frame_err <= 1'b0;
      else        frame_err <= done && busy_nx && (half_nx != wr_half);
   end

   p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err)
      else $error("error pulse longer than one cycle");
endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid, in_sof, out_rd, out_sof, cpu_we;
   logic [7:0] in_data;
   logic [4:0] cpu_addr, cpu_data;
   logic       out_valid, frame_err;
   logic [7:0] out_data;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   int err_seen = 0;

   // bench model state
   int m_buf [48];
   int m_shadow [24];
   int m_active [24];
   int m_wh, m_rh, m_busy, m_islot, m_oslot;

   always #5 clk = ~clk;

   tsi_switch uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_data(in_data), .out_rd(out_rd), .out_sof(out_sof),
      .out_valid(out_valid), .out_data(out_data), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_data(cpu_data), .frame_err(frame_err));

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, predict, check at the next negedge
   task automatic cycle(input bit iv, input bit isof, input int id,
                        input bit ord, input bit osof,
                        input bit we, input int wa, input int wd, input string tag);
      int ev, ed, ee, cur, h, done;
      in_valid = iv; in_sof = isof; in_data = id[7:0];
      out_rd = ord; out_sof = osof;
      cpu_we = we; cpu_addr = wa[4:0]; cpu_data = wd[4:0];
      ev = 0; ed = 0; ee = 0; done = 0;
      if (ord) begin
         cur = osof ? 0 : m_oslot;
         h   = osof ? 1 - m_wh : m_rh;
         if (cur < 24) begin
            ev = 1; ed = m_buf[h*24 + cur];
            if (osof) begin m_busy = 1; m_rh = h; end
            if (cur == 23) m_busy = 0;
            m_oslot = cur + 1;
         end
      end
      if (iv) begin
         cur = isof ? 0 : m_islot;
         if (isof) for (int k = 0; k < 24; k++) m_active[k] = m_shadow[k];
         if (cur < 24) begin
            m_buf[m_wh*24 + m_active[cur]] = id & 255;
            done = (cur == 23);
            m_islot = cur + 1;
         end
      end
      if (done) begin
         ee = (m_busy != 0) && (m_rh != m_wh);
         m_wh = 1 - m_wh;
      end
      if (we && wa < 24 && wd < 24) m_shadow[wa] = wd;
      @(posedge clk);
      @(negedge clk);
      check(out_valid == ev[0], "R3", "out_valid", int'(out_valid), ev);
      if (ev != 0) check(int'(out_data) == ed, tag, "out_data", int'(out_data), ed);
      check(frame_err == ee[0], "R9", "frame_err", int'(frame_err), ee);
      if (ee != 0) err_seen++;
   endtask

   task automatic run_phase(input int gap, input int delay, input int ncyc,
                            input int cpu_pct, input bit extra, input string tag);
      int len, s0, burst;
      len = 24 * (gap + 1);
      s0  = 23 * (gap + 1) + 1 + delay;
      burst = extra ? 26 : 24;
      for (int c = 0; c < ncyc; c++) begin
         int pos, rel, slot;
         bit iv, isof, ord, osof, we;
         pos  = c % len;
         iv   = (pos % (gap + 1)) == 0;
         slot = pos / (gap + 1);
         isof = iv && slot == 0;
         if (extra && gap > 0 && pos == len - 1) iv = 1;  // slot 24: dropped (R7)
         rel  = c - s0;
         ord  = rel >= 0 && (rel % len) < burst;
         osof = ord && (rel % len) == 0;
         we   = ($urandom % 100) < cpu_pct;
         cycle(iv, isof, int'($urandom % 256), ord, osof, we,
               int'($urandom % 32), int'($urandom % 32), tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      for (int k = 0; k < 48; k++) m_buf[k] = 0;
      for (int k = 0; k < 24; k++) begin m_shadow[k] = k; m_active[k] = k; end
      m_wh = 0; m_rh = 0; m_busy = 0; m_islot = 24; m_oslot = 24;
      rst_n = 1'b0; in_valid = 0; in_sof = 0; in_data = 0;
      out_rd = 0; out_sof = 0; cpu_we = 0; cpu_addr = 0; cpu_data = 0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: idle outputs after reset
      check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
      check(frame_err == 1'b0, "R1", "frame_err after reset", int'(frame_err), 0);
      // R1: bytes before first frame strobe are dropped; nothing read
      cycle(1, 0, 8'hAA, 0, 0, 0, 0, 0, "R1");
      // R2: identity map from reset, no table writes
      run_phase(1, 0, 48 * 4, 0, 0, "R2");
      // R5: table rewritten at random moments, including strobe cycles
      run_phase(1, 5, 48 * 6, 30, 0, "R5");
      // R6: frequent writes, many out of range
      run_phase(1, 3, 48 * 4, 70, 0, "R6");
      // R8: largest legal output lag
      run_phase(1, 24, 48 * 5, 20, 0, "R8");
      run_phase(2, 48, 72 * 4, 20, 0, "R8");
      // R7: extra input byte and extra read strobes past slot 23
      run_phase(1, 10, 48 * 4, 20, 1, "R7");
      // R4: back-to-back frames with zero lag, release in same cycle
      run_phase(0, 0, 24 * 8, 20, 0, "R4");
      // R9: one-cycle lag with continuous input must raise errors
      err_seen = 0;
      run_phase(0, 1, 24 * 6, 10, 0, "R9");
      check(err_seen > 0, "R9", "error pulses seen", err_seen, 1);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule